// File: doc/BRIEF.md
# Descriptor-Chain Transmit DMA

This block sends packets held in byte memory out on a byte stream, one descriptor at a time. The descriptors sit in a small on-chip word memory that software fills through the same register port that holds the control, head and completion registers. Each descriptor is four words: a link to the next descriptor, a buffer byte address, a buffer length word (kept for software, not used by the engine), and a mode/status word. The engine follows the links until it meets a null link. It writes status back into each finished descriptor, returning it to software, and raises a completion interrupt.

Software starts a queue by writing a descriptor address to the head register. It acknowledges work by writing the last finished descriptor address to the completion register. When the engine stops on a null link it flags end-of-queue in that descriptor. Software that linked a descriptor too late sees the flag and writes the head register again. A transmit-enable bit can park the engine at a descriptor boundary. A self-clearing soft-reset bit aborts everything.

The state machine has six states. IDLE moves to LOAD_NEXT when enabled with a nonzero head. LOAD_NEXT moves to LOAD_BUF, and LOAD_BUF to LOAD_MODE. LOAD_MODE moves to SEND when the descriptor is owned by hardware, and back to IDLE when it is not. SEND moves to WRITEBACK after the last byte is accepted. WRITEBACK always returns to IDLE. A soft reset forces IDLE from any state.

Top module: `tx_desc_dma`

## Requirements
- R1: After reset tx_valid and irq are 0 and the control (address 0x40), head (0x41) and completion (0x42) registers read 0; bus addresses below 0x40 reach descriptor memory word by word.
- R2: With control bit 0 (enable) set, writing a nonzero descriptor word address to the head register makes the engine read the descriptor at words +0 (next), +1 (buffer byte address) and +3 (mode) and emit the bytes from buffer address upward, count taken from mode bits 10:0, with tx_last on the final byte when mode bit 30 (end of packet) is set.
- R3: A descriptor with mode bit 30 set and a length below 60 is sent as exactly 60 bytes, the bytes past the length being zero; lengths of 60 or more are sent unpadded.
- R4: On completion the engine rewrites the mode word with bit 29 (owner) cleared and all other bits kept, and sets bit 28 (end of queue) only when the next link is zero, after which the head register reads 0.
- R5: A nonzero next link is followed without software action, the chained descriptors being sent back to back in link order.
- R6: A descriptor whose mode bit 29 is 0 is not sent: no byte leaves, its mode word is left unchanged, and the head register reads 0.
- R7: irq rises when a descriptor completes and stays high until the completion register is written with the address of the last completed descriptor; any other value leaves it high.
- R8: Clearing the enable bit during a packet lets that descriptor finish and write back, then parks the engine with the head register showing the next descriptor; setting enable again resumes there.
- R9: Writing control bit 1 (soft reset) aborts any transfer, clears the head and completion registers and irq, and the bit reads 0 again two cycles after the write.
- R10: A head-register write while a descriptor is being fetched or sent is ignored; the head register keeps showing the descriptor in flight.
- R11: A head-register write that lands in the writeback cycle of a final descriptor takes precedence over the end-of-queue clear, so the newly written chain is started.
- R12: While tx_valid is high and tx_ready is low, tx_data and byte_addr hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register/descriptor write strobe |
| bus_addr | input | 7 | Word address: below 0x40 descriptor memory, 0x40 control, 0x41 head, 0x42 completion |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| byte_addr | output | 16 | Packet byte address to the byte source |
| byte_rd | output | 1 | A real payload byte is being read |
| byte_data | input | 8 | Byte returned in the same cycle for byte_addr |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink accepts the byte |
| tx_last | output | 1 | Last byte of a packet |
| irq | output | 1 | Pending completion |

## Verification
The engine's own end-of-queue writeback, which clears the head register, and a software head write can fall in the same cycle. The bench waits for the handshake of the final byte of a lone descriptor, then places a head write exactly in the following cycle, which is the writeback cycle. It judges the outcome by requiring the old descriptor to carry the end-of-queue flag while the newly written descriptor is still sent in full, with the head register back at zero afterwards.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_NEXT,
        ST_LOAD_BUF,
        ST_LOAD_MODE,
        ST_SEND,
        ST_WRITEBACK
    } dma_state_e;

    localparam int MODE_SOP   = 31;
    localparam int MODE_EOP   = 30;
    localparam int MODE_OWN   = 29;
    localparam int MODE_EOQ   = 28;
    localparam int LEN_W      = 11;
    localparam int MIN_FRAME  = 60;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_HEAD = 2'd1;
    localparam logic [1:0] REG_CP   = 2'd2;

endpackage

// File: rtl/tx_desc_ram.sv
module tx_desc_ram #(
    parameter int AW = 6,
    localparam int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [31:0]   eng_wdata,
    output logic [31:0]   eng_rdata
);

    logic [31:0] mem [WORDS];
    logic        collide;

    assign collide   = eng_we && bus_we && (eng_addr == bus_addr);
    assign bus_rdata = mem[bus_addr];
    assign eng_rdata = mem[eng_addr];

    always_ff @(posedge clk) begin
        if (eng_we)
            mem[eng_addr] <= eng_wdata;
        if (bus_we && !collide)
            mem[bus_addr] <= bus_wdata;
    end

    // R4: status writeback is never lost to a same-word software write
    a_r4_engine_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> (mem[$past(eng_addr)] == $past(eng_wdata)));

endmodule

// File: rtl/tx_dma_regs.sv
module tx_dma_regs
    import tx_dma_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          head_wr_ok,
    input  logic          eng_head_ld,
    input  logic [AW-1:0] eng_head_val,
    input  logic          done_fire,
    input  logic [AW-1:0] done_addr,
    output logic          tx_en,
    output logic          srst,
    output logic [AW-1:0] head,
    output logic          irq
);

    logic [AW-1:0] cp_q;
    logic [AW-1:0] last_q;
    logic          wr_ctrl, wr_head, wr_cp, ack_match;

    assign wr_ctrl   = reg_we && (reg_sel == REG_CTRL);
    assign wr_head   = reg_we && (reg_sel == REG_HEAD);
    assign wr_cp     = reg_we && (reg_sel == REG_CP);
    assign ack_match = (reg_wdata == 32'(last_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en  <= 1'b0;
            srst   <= 1'b0;
            head   <= '0;
            cp_q   <= '0;
            last_q <= '0;
            irq    <= 1'b0;
        end else begin
            srst <= wr_ctrl && reg_wdata[1];
            if (wr_ctrl)
                tx_en <= reg_wdata[0];
            if (srst) begin
                head   <= '0;
                cp_q   <= '0;
                last_q <= '0;
                irq    <= 1'b0;
            end else begin
                if (wr_head && head_wr_ok)
                    head <= reg_wdata[AW-1:0];
                else if (eng_head_ld)
                    head <= eng_head_val;
                if (wr_cp)
                    cp_q <= reg_wdata[AW-1:0];
                if (done_fire) begin
                    last_q <= done_addr;
                    irq    <= 1'b1;
                end else if (wr_cp && ack_match) begin
                    irq    <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            REG_CTRL: reg_rdata = {30'd0, srst, tx_en};
            REG_HEAD: reg_rdata = 32'(head);
            REG_CP:   reg_rdata = 32'(cp_q);
            default:  reg_rdata = 32'd0;
        endcase
    end

    // R7: a completion always leaves the interrupt pending
    a_r7_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_fire && !srst) |=> irq);

    // R9: soft reset empties the pointers and the interrupt
    a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (head == '0 && cp_q == '0 && !irq));

    // R10: a refused head write leaves the head unchanged unless the engine loads it
    a_r10_busy_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_head && !head_wr_ok && !eng_head_ld && !srst) |=> $stable(head));

endmodule

// File: rtl/tx_dma_fsm.sv
module tx_dma_fsm
    import tx_dma_pkg::*;
#(
    parameter int AW      = 6,
    parameter int BYTE_AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               srst,
    input  logic [AW-1:0]      head,
    output logic [AW-1:0]      mem_addr,
    output logic               mem_we,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    output logic [BYTE_AW-1:0] byte_addr,
    output logic               byte_rd,
    input  logic [7:0]         byte_data,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               tx_last,
    output logic               head_ld,
    output logic [AW-1:0]      head_val,
    output logic               head_wr_ok,
    output logic               done_fire,
    output logic [AW-1:0]      done_addr
);

    localparam logic [LEN_W-1:0] PAD_LEN = LEN_W'(MIN_FRAME);

    dma_state_e         state_q, state_d;
    logic [AW-1:0]      cur_q, nxt_q;
    logic [BYTE_AW-1:0] bptr_q;
    logic [31:0]        mode_q;
    logic [LEN_W-1:0]   idx_q, total_q;
    logic [LEN_W-1:0]   ld_len, pkt_len;
    logic               start, ld_own, ld_eop, final_byte;

    assign start      = !srst && tx_en && (head != '0);
    assign ld_own     = mem_rdata[MODE_OWN];
    assign ld_eop     = mem_rdata[MODE_EOP];
    assign ld_len     = mem_rdata[LEN_W-1:0];
    assign pkt_len    = mode_q[LEN_W-1:0];
    assign final_byte = (idx_q == total_q - 1'b1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_LOAD_NEXT;
            ST_LOAD_NEXT: state_d = ST_LOAD_BUF;
            ST_LOAD_BUF:  state_d = ST_LOAD_MODE;
            ST_LOAD_MODE: state_d = ld_own ? ST_SEND : ST_IDLE;
            ST_SEND:      if (tx_ready && final_byte) state_d = ST_WRITEBACK;
            ST_WRITEBACK: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
        if (srst)
            state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // descriptor working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            nxt_q   <= '0;
            bptr_q  <= '0;
            mode_q  <= '0;
            idx_q   <= '0;
            total_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (start) cur_q <= head;
                ST_LOAD_NEXT: nxt_q <= mem_rdata[AW-1:0];
                ST_LOAD_BUF:  bptr_q <= mem_rdata[BYTE_AW-1:0];
                ST_LOAD_MODE: begin
                    mode_q <= mem_rdata;
                    idx_q  <= '0;
                    if (ld_eop && ld_len < PAD_LEN)
                        total_q <= PAD_LEN;
                    else if (ld_len == '0)
                        total_q <= LEN_W'(1);
                    else
                        total_q <= ld_len;
                end
                ST_SEND:      if (tx_ready) idx_q <= idx_q + 1'b1;
                default:      ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr   = cur_q;
        mem_we     = 1'b0;
        mem_wdata  = mode_q;
        tx_valid   = 1'b0;
        head_ld    = 1'b0;
        head_val   = '0;
        done_fire  = 1'b0;
        head_wr_ok = 1'b0;
        unique case (state_q)
            ST_IDLE:      head_wr_ok = !(tx_en && head != '0);
            ST_LOAD_NEXT: mem_addr = cur_q;
            ST_LOAD_BUF:  mem_addr = cur_q + AW'(1);
            ST_LOAD_MODE: begin
                mem_addr = cur_q + AW'(3);
                head_ld  = !ld_own;
            end
            ST_SEND:      tx_valid = !srst;
            ST_WRITEBACK: begin
                mem_addr   = cur_q + AW'(3);
                mem_we     = !srst;
                done_fire  = !srst;
                head_ld    = 1'b1;
                head_val   = nxt_q;
                head_wr_ok = 1'b1;
                mem_wdata[MODE_OWN] = 1'b0;
                if (nxt_q == '0)
                    mem_wdata[MODE_EOQ] = 1'b1;
            end
            default:      ;
        endcase
        done_addr = cur_q;
        byte_addr = bptr_q + BYTE_AW'(idx_q);
        byte_rd   = tx_valid && (idx_q < pkt_len);
        tx_data   = byte_rd ? byte_data : 8'd0;
        tx_last   = tx_valid && final_byte && mode_q[MODE_EOP];
    end

    // R12: an unaccepted byte is held
    a_r12_hold_data: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(byte_addr)));

    // R2: the byte after the last one of a descriptor is not streamed at once
    a_r2_last_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    // R6: an unowned descriptor produces no stream
    a_r6_unowned_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD_MODE && !mem_rdata[MODE_OWN]) |=> !tx_valid);

    // R4: status is written back only after the stream of that descriptor ended
    a_r4_wb_after_send: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(tx_valid) && $past(tx_ready)));

endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma
    import tx_dma_pkg::*;
#(
    parameter int DESC_AW = 6,
    parameter int BYTE_AW = 16,
    localparam int BUS_AW = DESC_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [BYTE_AW-1:0] byte_addr,
    output logic               byte_rd,
    input  logic [7:0]         byte_data,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               tx_last,
    output logic               irq
);

    logic                reg_space;
    logic [31:0]         ram_rdata, reg_rdata, eng_rdata, eng_wdata;
    logic [DESC_AW-1:0]  eng_addr, head, head_val, done_addr;
    logic                eng_we, tx_en, srst, head_ld, head_wr_ok, done_fire;

    assign reg_space = bus_addr[BUS_AW-1];
    assign bus_rdata = reg_space ? reg_rdata : ram_rdata;

    tx_desc_ram #(.AW(DESC_AW)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we && !reg_space),
        .bus_addr  (bus_addr[DESC_AW-1:0]),
        .bus_wdata (bus_wdata),
        .bus_rdata (ram_rdata),
        .eng_we    (eng_we),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata),
        .eng_rdata (eng_rdata)
    );

    tx_dma_regs #(.AW(DESC_AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (bus_we && reg_space),
        .reg_sel      (bus_addr[1:0]),
        .reg_wdata    (bus_wdata),
        .reg_rdata    (reg_rdata),
        .head_wr_ok   (head_wr_ok),
        .eng_head_ld  (head_ld),
        .eng_head_val (head_val),
        .done_fire    (done_fire),
        .done_addr    (done_addr),
        .tx_en        (tx_en),
        .srst         (srst),
        .head         (head),
        .irq          (irq)
    );

    tx_dma_fsm #(.AW(DESC_AW), .BYTE_AW(BYTE_AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .srst       (srst),
        .head       (head),
        .mem_addr   (eng_addr),
        .mem_we     (eng_we),
        .mem_wdata  (eng_wdata),
        .mem_rdata  (eng_rdata),
        .byte_addr  (byte_addr),
        .byte_rd    (byte_rd),
        .byte_data  (byte_data),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_last    (tx_last),
        .head_ld    (head_ld),
        .head_val   (head_val),
        .head_wr_ok (head_wr_ok),
        .done_fire  (done_fire),
        .done_addr  (done_addr)
    );

    // R1: nothing streams or interrupts in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !irq));

endmodule

// File: tb/tx_desc_dma_test.sv
`timescale 1ns/1ps
module tx_desc_dma_test;

    localparam logic [6:0] A_CTRL = 7'h40;
    localparam logic [6:0] A_HEAD = 7'h41;
    localparam logic [6:0] A_CP   = 7'h42;

    // {backpressure, spare[3:0], buffer address[15:0], length[10:0]}
    localparam logic [31:0] VEC [0:4] = '{
        {1'b0, 4'd0, 16'h0100, 11'd1},
        {1'b0, 4'd0, 16'h0230, 11'd59},
        {1'b1, 4'd0, 16'h0400, 11'd60},
        {1'b0, 4'd0, 16'h1234, 11'd61},
        {1'b1, 4'd0, 16'h2F00, 11'd100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] byte_addr;
    logic        byte_rd;
    logic [7:0]  byte_data;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last, irq;
    logic        tx_ready;
    logic        rdy_mode = 1'b0;
    logic [1:0]  cyc = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] cap [0:511];
    int ncap = 0;
    int nlast = 0;
    int lastpos = -1;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 2'd1;
    assign tx_ready = rdy_mode ? (cyc != 2'd0) : 1'b1;

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign byte_data = src_byte(byte_addr);

    tx_desc_dma uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .byte_addr(byte_addr),
        .byte_rd(byte_rd), .byte_data(byte_data), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last), .irq(irq)
    );

    always @(negedge clk) begin
        if (tx_valid && tx_ready) begin
            if (ncap < 512) cap[ncap] = tx_data;
            if (tx_last) begin
                nlast = nlast + 1;
                lastpos = ncap;
            end
            ncap = ncap + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic put_desc(input int base, input int nxt, input int bufp,
                            input int len, input logic [31:0] flags);
        wr(7'(base),     32'(nxt));
        wr(7'(base + 1), 32'(bufp));
        wr(7'(base + 2), 32'(len));
        wr(7'(base + 3), flags | 32'(len));
    endtask

    task automatic wait_head_zero();
        logic [31:0] v;
        for (int k = 0; k < 2000; k++) begin
            rd(A_HEAD, v);
            if (v == 0) break;
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_cap();
        ncap = 0; nlast = 0; lastpos = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual 1 expected 0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int len, bufp, tot, bad;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!tx_valid, "R1", "tx_valid after reset", tx_valid, 0);
        chk(!irq, "R1", "irq after reset", irq, 0);
        rd(A_CTRL, v); chk(v == 0, "R1", "ctrl after reset", v, 0);
        rd(A_HEAD, v); chk(v == 0, "R1", "head after reset", v, 0);
        rd(A_CP, v);   chk(v == 0, "R1", "completion after reset", v, 0);
        wr(7'd5, 32'hCAFE_0001);
        rd(7'd5, v);   chk(v == 32'hCAFE_0001, "R1", "descriptor word readback", v, 32'hCAFE_0001);

        wr(A_CTRL, 32'd1);

        // R2, R3, R4, R12: table of single descriptors
        for (int r = 0; r < 5; r++) begin
            len  = int'(VEC[r][10:0]);
            bufp = int'(VEC[r][26:11]);
            rdy_mode = VEC[r][31];
            tot = (len < 60) ? 60 : len;
            put_desc(4, 0, bufp, len, 32'hE000_0000);
            wr(A_CP, 32'd4);
            clear_cap();
            wr(A_HEAD, 32'd4);
            wait_head_zero();
            wait_cycles(2);
            chk(ncap == tot, "R3", "byte count", ncap, tot);
            bad = 0;
            for (int i = 0; i < tot && i < 512; i++)
                if (cap[i] != ((i < len) ? src_byte(16'(bufp + i)) : 8'd0)) bad++;
            chk(bad == 0, VEC[r][31] ? "R12" : "R2", "mismatched bytes", bad, 0);
            chk(nlast == 1 && lastpos == tot - 1, "R2", "tx_last position", lastpos, tot - 1);
            rd(7'd7, v);
            chk(v == (32'hD000_0000 | 32'(len)), "R4", "written-back mode", v, 32'hD000_0000 | 32'(len));
            chk(irq, "R7", "irq after completion", irq, 1);
        end
        rdy_mode = 1'b0;

        // R7: acknowledge with a wrong then the right address
        wr(A_CP, 32'd8);
        wait_cycles(1);
        chk(irq, "R7", "irq after mismatched ack", irq, 0 + 1);
        wr(A_CP, 32'd4);
        wait_cycles(1);
        chk(!irq, "R7", "irq after matching ack", irq, 0);
        rd(A_CP, v); chk(v == 4, "R7", "completion register readback", v, 4);

        // R5: chain of three
        put_desc(4, 8, 16'h0500, 10, 32'hE000_0000);
        put_desc(8, 12, 16'h0600, 70, 32'hE000_0000);
        put_desc(12, 0, 16'h0700, 3, 32'hE000_0000);
        clear_cap();
        wr(A_HEAD, 32'd4);
        wait_head_zero();
        wait_cycles(2);
        chk(ncap == 190, "R5", "chained byte count", ncap, 190);
        chk(nlast == 3, "R5", "chained packet count", nlast, 3);
        chk(cap[60] == src_byte(16'h0600), "R5", "second packet first byte", cap[60], src_byte(16'h0600));
        rd(7'd7, v);  chk(v == 32'hC000_000A, "R4", "first mode no EOQ", v, 32'hC000_000A);
        rd(7'd11, v); chk(v == 32'hC000_0046, "R4", "middle mode no EOQ", v, 32'hC000_0046);
        rd(7'd15, v); chk(v == 32'hD000_0003, "R4", "tail mode with EOQ", v, 32'hD000_0003);
        wr(A_CP, 32'd12);
        wait_cycles(1);
        chk(!irq, "R7", "irq cleared by tail ack", irq, 0);

        // R6: descriptor owned by software
        put_desc(4, 0, 16'h0800, 20, 32'hC000_0000);
        clear_cap();
        wr(A_HEAD, 32'd4);
        wait_cycles(12);
        rd(A_HEAD, v); chk(v == 0, "R6", "head after unowned", v, 0);
        chk(ncap == 0, "R6", "bytes from unowned", ncap, 0);
        rd(7'd7, v); chk(v == 32'hC000_0014, "R6", "unowned mode untouched", v, 32'hC000_0014);
        chk(!irq, "R6", "no completion for unowned", irq, 0);

        // R10: head write while busy
        put_desc(4, 0, 16'h0900, 100, 32'hE000_0000);
        put_desc(8, 0, 16'h0A00, 10, 32'hE000_0000);
        clear_cap();
        wr(A_HEAD, 32'd4);
        wait_cycles(20);
        wr(A_HEAD, 32'd8);
        rd(A_HEAD, v); chk(v == 4, "R10", "head during busy write", v, 4);
        wait_head_zero();
        wait_cycles(10);
        chk(ncap == 100, "R10", "bytes after ignored write", ncap, 100);
        rd(7'd11, v); chk(v == 32'hE000_000A, "R10", "ignored descriptor untouched", v, 32'hE000_000A);
        wr(A_CP, 32'd4);

        // R8: pause at descriptor boundary
        put_desc(4, 8, 16'h0B00, 60, 32'hE000_0000);
        put_desc(8, 0, 16'h0C00, 60, 32'hE000_0000);
        clear_cap();
        wr(A_HEAD, 32'd4);
        wait_cycles(10);
        wr(A_CTRL, 32'd0);
        wait_cycles(150);
        rd(A_HEAD, v); chk(v == 8, "R8", "head while parked", v, 8);
        chk(ncap == 60, "R8", "bytes while parked", ncap, 60);
        rd(7'd11, v); chk(v == 32'hE000_003C, "R8", "parked descriptor untouched", v, 32'hE000_003C);
        wr(A_CTRL, 32'd1);
        wait_head_zero();
        wait_cycles(2);
        chk(ncap == 120, "R8", "bytes after resume", ncap, 120);
        wr(A_CP, 32'd8);

        // R11: head write in the end-of-queue writeback cycle
        put_desc(4, 0, 16'h0D00, 60, 32'hE000_0000);
        put_desc(8, 0, 16'h0E00, 60, 32'hE000_0000);
        clear_cap();
        wr(A_HEAD, 32'd4);
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (tx_valid && tx_ready && tx_last) break;
        end
        wr(A_HEAD, 32'd8);
        wait_head_zero();
        wait_cycles(2);
        chk(ncap == 120, "R11", "bytes after late head write", ncap, 120);
        rd(7'd7, v);  chk(v == 32'hD000_003C, "R11", "old tail EOQ", v, 32'hD000_003C);
        rd(7'd11, v); chk(v == 32'hD000_003C, "R11", "new descriptor done", v, 32'hD000_003C);

        // R9: soft reset in the middle of a packet
        wr(A_CP, 32'd5);
        put_desc(4, 0, 16'h0F00, 100, 32'hE000_0000);
        clear_cap();
        wr(A_HEAD, 32'd4);
        wait_cycles(20);
        wr(A_CTRL, 32'd3);
        @(negedge clk);
        rd(A_CTRL, v); chk(v == 1, "R9", "ctrl after soft reset", v, 1);
        rd(A_HEAD, v); chk(v == 0, "R9", "head after soft reset", v, 0);
        rd(A_CP, v);   chk(v == 0, "R9", "completion after soft reset", v, 0);
        chk(!irq, "R9", "irq after soft reset", irq, 0);
        chk(!tx_valid, "R9", "stream stopped", tx_valid, 0);
        bad = ncap;
        wait_cycles(100);
        chk(ncap == bad && ncap < 100, "R9", "no bytes after soft reset", ncap, bad);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule